// File: doc/BRIEF.md
# Opcode-Steered Signed Add/Sub/Abs Unit

This block is a combinational arithmetic unit for small two's complement operands. A 3-bit opcode chooses one of three operations: a sum, a difference in either operand order, or the magnitude of one operand. The unit returns a two's complement result and a flag that marks results that do not fit in the result width.

A single ripple adder/subtractor built from full adders does all of the arithmetic. A front stage picks the two adder inputs and the carry-in from the opcode. It swaps the operands when the opcode asks for it and forces the first adder input to zero for a magnitude request. A subtraction inverts the second adder input and injects a carry-in of one. Nothing in the block is clocked, so the outputs follow the inputs after the adder chain settles.

Top module: `opsel_arith_unit`

## Requirements
- R1: `lhs`, `rhs` and `result` are W-bit two's complement values (W defaults to 4), and `opcode` is 3 bits wide.
- R2: With opcode bit 0 low and bit 2 high, `result` is lhs+rhs when opcode bit 1 is 0 and lhs−rhs when opcode bit 1 is 1.
- R3: With opcode bits 0 and 2 both low, `result` is rhs+lhs when opcode bit 1 is 0 and rhs−lhs when opcode bit 1 is 1.
- R4: With opcode bit 0 high, `result` is |rhs| when opcode bit 2 is 1 and |lhs| when it is 0. Opcode bit 1 does not affect `result` or `overflow`.
- R5: `overflow` is 1 exactly when the true result lies outside −2^(W−1) .. 2^(W−1)−1. `result` always holds the low W bits of the true result.
- R6: The magnitude of the most negative value (4'b1000 at W=4) raises `overflow`, and `result` reads 4'b1000.
- R7: The unit holds no state. `result` and `overflow` depend only on the present inputs, whatever order the inputs were applied in before.
- R8: A sum of operands with different sign bits never overflows, and neither does a difference of operands with equal sign bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lhs | input | W | First two's complement operand |
| rhs | input | W | Second two's complement operand |
| opcode | input | 3 | Operation select |
| result | output | W | Two's complement result |
| overflow | output | 1 | Result is out of range and not valid |

## Verification
The bench applies every operand pair under all eight opcodes. The checks that matter most are the edges of the signed range. If the carry-in on subtraction were missing, every difference would come out one too low. If overflow were taken from the carry out of the top bit alone, it would trip on ordinary negative sums and stay low on positive wraparound. A magnitude path that inverted without adding one, or that tested the wrong operand's sign bit, would give wrong values for negative inputs. It would also miss the overflow on the most negative value. If the operand swap were reversed, the opcodes that differ only in bit 2 would give negated differences and magnitudes of the wrong operand.

// File: rtl/opsel_arith_unit.sv
module oau_full_adder (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (ci & (a ^ b));
endmodule

module oau_ripple_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W:0]   carry;
  logic [W-1:0] y_eff;

  assign carry[0] = sub;
  assign y_eff    = y ^ {W{sub}};

  for (genvar i = 0; i < W; i++) begin : g_bit
    oau_full_adder u_fa (
      .a (x[i]),
      .b (y_eff[i]),
      .ci(carry[i]),
      .s (sum[i]),
      .co(carry[i+1])
    );
  end

  assign ovf = carry[W] ^ carry[W-1];
endmodule

module opsel_arith_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic [2:0]   opcode,
  output logic [W-1:0] result,
  output logic         overflow
);
  logic         is_abs;
  logic [W-1:0] first_op, second_op;
  logic [W-1:0] x_in, y_in;
  logic         do_sub;

  assign is_abs    = opcode[0];
  assign first_op  = opcode[2] ? lhs : rhs;
  assign second_op = opcode[2] ? rhs : lhs;

  assign x_in   = is_abs ? '0 : first_op;
  assign y_in   = second_op;
  assign do_sub = is_abs ? second_op[W-1] : opcode[1];

  oau_ripple_addsub #(.W(W)) u_core (
    .x  (x_in),
    .y  (y_in),
    .sub(do_sub),
    .sum(result),
    .ovf(overflow)
  );
endmodule

module opsel_arith_unit_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] lhs,
  input logic [W-1:0] rhs,
  input logic [2:0]   opcode,
  input logic [W-1:0] result,
  input logic         overflow
);
  logic [W-1:0] mag_src;
  assign mag_src = opcode[2] ? rhs : lhs;

  always_comb begin
    // R4
    abs_sign_chk: assert (!(opcode[0] && !overflow) || !result[W-1]);
    // R6
    abs_ovf_src_chk: assert (!(opcode[0] && overflow) || (mag_src == {1'b1, {(W-1){1'b0}}}));
    // R6
    abs_ovf_val_chk: assert (!(opcode[0] && overflow) || (result == {1'b1, {(W-1){1'b0}}}));
    // R8
    mixed_sum_chk: assert (!(!opcode[0] && !opcode[1] && (lhs[W-1] != rhs[W-1])) || !overflow);
    // R8
    same_diff_chk: assert (!(!opcode[0] && opcode[1] && (lhs[W-1] == rhs[W-1])) || !overflow);
    // R2
    add_fwd_chk: assert (!(opcode == 3'b100) || (result == W'(lhs + rhs)));
  end
endmodule

bind opsel_arith_unit opsel_arith_unit_chk #(.W(W)) u_chk (
  .lhs(lhs), .rhs(rhs), .opcode(opcode), .result(result), .overflow(overflow)
);

// File: tb/tb_opsel_arith_unit.sv
module tb_opsel_arith_unit;
  logic       clk = 0;
  logic [3:0] lhs, rhs;
  logic [2:0] opcode;
  logic [3:0] result;
  logic       overflow;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  opsel_arith_unit #(.W(4)) dut (
    .lhs(lhs), .rhs(rhs), .opcode(opcode), .result(result), .overflow(overflow)
  );

  task automatic check(input string tag, input logic [3:0] gr, input logic go,
                       input logic [3:0] er, input logic eo);
    tests++;
    if (gr !== er || go !== eo) begin
      fails++;
      $display("FAIL %s op=%b a=%h b=%h: got r=%h ovf=%b exp r=%h ovf=%b",
               tag, opcode, lhs, rhs, gr, go, er, eo);
    end
  endtask

  function automatic int sval(input logic [3:0] v);
    return v[3] ? int'(v) - 16 : int'(v);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    lhs = 0; rhs = 0; opcode = 3'b100;
    @(negedge clk);
    check("R1 zero inputs", result, overflow, 4'h0, 1'b0);

    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          int sa, sb, t;
          string tag;
          @(posedge clk); #2;
          lhs = 4'(a); rhs = 4'(b); opcode = 3'(op);
          sa = sval(4'(a)); sb = sval(4'(b));
          if (op[0]) begin
            t = op[2] ? (sb < 0 ? -sb : sb) : (sa < 0 ? -sa : sa);
            tag = ((op[2] && b == 8) || (!op[2] && a == 8)) ? "R6" : "R4";
          end else if (op[2]) begin
            t = op[1] ? sa - sb : sa + sb;
            tag = "R2";
          end else begin
            t = op[1] ? sb - sa : sb + sa;
            tag = "R3";
          end
          @(negedge clk);
          check(tag, result, overflow, 4'(t), (t > 7 || t < -8));
          if (!op[0] && ((!op[1] && a[3] != b[3]) || (op[1] && a[3] == b[3])))
            check("R8", result, overflow, 4'(t), 1'b0);
          if (t > 7 || t < -8)
            check("R5", result, overflow, 4'(t), 1'b1);
        end
      end
    end

    // R7: same inputs after a different history give the same outputs
    @(posedge clk); #2; lhs = 4'h8; rhs = 4'h8; opcode = 3'b101;
    @(posedge clk); #2; lhs = 4'h3; rhs = 4'h5; opcode = 3'b010;
    @(negedge clk);
    check("R7", result, overflow, 4'h2, 1'b0);
    @(posedge clk); #2; lhs = 4'hF; rhs = 4'h7; opcode = 3'b000;
    @(posedge clk); #2; lhs = 4'h3; rhs = 4'h5; opcode = 3'b010;
    @(negedge clk);
    check("R7", result, overflow, 4'h2, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule